// File: doc/BRIEF.md
# Warp Issue Scheduler with Lane Masking

This block selects one resident warp per cycle and presents that warp's next instruction on a single dispatch port. Each warp has 32 lanes that advance together, a program counter, and an active-lane mask. The block picks among warps that are ready. It skips warps that are waiting on a memory load, warps that have exited, and warps whose execution unit is busy. This hides memory latency as long as some other warp has work.

Branch divergence is modelled inside the block. A branch carries a taken vector, an else-start address and a reconvergence address. Lanes that take the branch run the first path. The other lanes then run the second path. The full mask is restored at the reconvergence address. This uses a small per-warp stack. Load/store instructions go out as several consecutive narrow turns, because there are fewer load/store units than lanes.

The number of resident warps comes from the register budget. It is the register-file size divided by the registers one warp needs. The instruction fetch itself lives outside the block: the block exports each warp's program counter, and the environment returns that warp's current instruction.

Top module: `ws_sched`

## Requirements
- R1: After reset, every warp has program counter 0, a full 32-lane mask, and no pending load. Warp 0 is the first warp searched.
- R2: Among eligible warps, the search starts at the warp after the last warp granted a fresh issue and wraps around the warp count.
- R3: Op codes are 0 = arithmetic, 1 = load/store, 2 = branch, 3 = exit. Ops 0, 2 and 3 issue in one cycle, with the warp's whole active mask, which is never empty.
- R4: For a branch, let T = active & taken and E = active & ~taken. If T is empty, the PC jumps to the else-start. If E is empty, the lanes run PC+1 up to the else-start, then jump to the reconvergence PC. Otherwise the mask becomes T until the PC reaches the else-start, then becomes E until the PC reaches the reconvergence PC, and then the saved mask is restored.
- R5: After its last load/store turn, a warp is ineligible until its mem_done bit pulses. It becomes eligible in the cycle after the pulse.
- R6: A load/store issues as 4 turns of 8 lanes each. Turn k carries active lanes 8k to 8k+7. A turn advances only in a cycle with lsu_ready high, and no other warp issues until the last turn.
- R7: Warp w can be resident only when (w+1) × regs_per_thread × 32 ≤ 4096. A regs_per_thread of 0 makes all warps resident. A warp that is not resident never issues.
- R8: A fresh issue needs lsu_ready when the op is load/store, and alu_ready for any other op.
- R9: A warp that has issued an exit never issues again.
- R10: Within one warp, instructions issue in program order. issue_pc is the warp's current PC, which advances by one unless R4 redirects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regs_per_thread | input | 8 | Register budget of one lane; sets occupancy |
| alu_ready | input | 1 | Arithmetic/branch unit can accept an issue |
| lsu_ready | input | 1 | Load/store unit can accept a turn |
| mem_done | input | 4 | Per-warp load completion pulse |
| inst_op | input | 8 | Per-warp current op code, 2 bits per warp |
| inst_taken | input | 128 | Per-warp branch taken vector, 32 bits per warp |
| inst_tgt | input | 24 | Per-warp else-start address, 6 bits per warp |
| inst_rcv | input | 24 | Per-warp reconvergence address, 6 bits per warp |
| fetch_pc | output | 24 | Per-warp current PC, 6 bits per warp |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_warp | output | 2 | Id of the issuing warp |
| issue_op | output | 2 | Op code issued |
| issue_mask | output | 32 | Lanes executing this issue |
| issue_pc | output | 6 | PC of the issued instruction |

## Verification
The hardest situation to reach is nested divergence. It must overlap with a load/store sitting in the middle of a masked path while other warps compete for the port. Only then do the saved masks, the partial turn masks and the round-robin pointer all interact.

The stimulus gets there with per-warp programs. These programs nest two branches and place load/store ops inside the inner and outer paths. Random taken vectors are drawn for each phase, and alu_ready, lsu_ready and completion pulses are randomised. A bench model predicts every cycle's issue from these inputs. Phases with different register budgets cover the occupancy limit.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int WS_LANES = 32;

    typedef logic [WS_LANES-1:0] lane_mask_t;

    typedef enum logic [1:0] {
        OP_ALU  = 2'd0,
        OP_LDST = 2'd1,
        OP_BRA  = 2'd2,
        OP_EXIT = 2'd3
    } op_e;

    // lanes covered by one narrow load/store turn
    function automatic lane_mask_t lane_slice(input int unsigned turn, input int unsigned width);
        lane_mask_t m;
        for (int i = 0; i < WS_LANES; i++) begin
            m[i] = (i >= int'(turn * width)) && (i < int'((turn + 1) * width));
        end
        return m;
    endfunction

endpackage

// File: rtl/ws_occupancy.sv
module ws_occupancy
    import ws_pkg::*;
#(
    parameter int NW      = 4,
    parameter int RF_REGS = 4096,
    parameter int RPT_W   = 8
) (
    input  logic [RPT_W-1:0] regs_per_thread,
    output logic [NW-1:0]    resident
);
    logic [31:0] per_warp;

    always_comb begin
        per_warp = 32'(regs_per_thread) * 32'(WS_LANES);
        for (int k = 0; k < NW; k++) begin
            resident[k] = (regs_per_thread == '0) ||
                          ((32'(k + 1) * per_warp) <= 32'(RF_REGS));
        end
    end
endmodule

// File: rtl/ws_rr_arb.sv
module ws_rr_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] gnt,
    output logic          any
);
    always_comb begin
        automatic int idx;
        gnt = '0;
        any = 1'b0;
        for (int o = 1; o <= N; o++) begin
            idx = (int'(last) + o) % N;
            if (!any && req[idx]) begin
                any = 1'b1;
                gnt = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/ws_warp_ctx.sv
module ws_warp_ctx
    import ws_pkg::*;
#(
    parameter int PCW   = 6,
    parameter int DEPTH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           issue,
    input  logic           final_turn,
    input  op_e            op,
    input  lane_mask_t     taken,
    input  logic [PCW-1:0] tgt,
    input  logic [PCW-1:0] rcv,
    input  logic           mem_done,
    output logic [PCW-1:0] pc,
    output lane_mask_t     mask,
    output logic           pend,
    output logic           done
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SW = $clog2(DEPTH + 1);

    logic [PCW-1:0] stk_rpc  [DEPTH];
    logic [PCW-1:0] stk_npc  [DEPTH];
    lane_mask_t     stk_mask [DEPTH];
    logic [SW-1:0]  sp;

    logic [PCW-1:0] pc_inc;
    logic [AW-1:0]  top_i, nxt_i, nxt2_i;
    logic           pop_hit;
    lane_mask_t     t_lanes, e_lanes;

    always_comb begin
        pc_inc  = pc + 1'b1;
        top_i   = AW'(sp - 1'b1);
        nxt_i   = AW'(sp);
        nxt2_i  = AW'(sp + 1'b1);
        pop_hit = (sp != '0) && (pc_inc == stk_rpc[top_i]);
        t_lanes = mask & taken;
        e_lanes = mask & ~taken;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            mask <= '1;
            sp   <= '0;
            pend <= 1'b0;
            done <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                stk_rpc[i]  <= '0;
                stk_npc[i]  <= '0;
                stk_mask[i] <= '0;
            end
        end else begin
            if (mem_done) pend <= 1'b0;
            if (issue) begin
                case (op)
                    OP_ALU, OP_LDST: begin
                        if (op == OP_ALU || final_turn) begin
                            if (pop_hit) begin
                                pc   <= stk_npc[top_i];
                                mask <= stk_mask[top_i];
                                sp   <= sp - 1'b1;
                            end else begin
                                pc <= pc_inc;
                            end
                            if (op == OP_LDST) pend <= 1'b1;
                        end
                    end
                    OP_BRA: begin
                        if (t_lanes == '0) begin
                            pc <= tgt;
                        end else if (e_lanes == '0) begin
                            stk_rpc[nxt_i]  <= tgt;
                            stk_npc[nxt_i]  <= rcv;
                            stk_mask[nxt_i] <= mask;
                            sp <= sp + 1'b1;
                            pc <= pc_inc;
                        end else begin
                            stk_rpc[nxt_i]   <= rcv;
                            stk_npc[nxt_i]   <= rcv;
                            stk_mask[nxt_i]  <= mask;
                            stk_rpc[nxt2_i]  <= tgt;
                            stk_npc[nxt2_i]  <= tgt;
                            stk_mask[nxt2_i] <= e_lanes;
                            sp   <= sp + 2'd2;
                            mask <= t_lanes;
                            pc   <= pc_inc;
                        end
                    end
                    default: done <= 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/ws_sched.sv
module ws_sched
    import ws_pkg::*;
#(
    parameter int NW        = 4,
    parameter int PCW       = 6,
    parameter int RF_REGS   = 4096,
    parameter int LSU_LANES = 8,
    parameter int STK_DEPTH = 4,
    parameter int RPT_W     = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [RPT_W-1:0]       regs_per_thread,
    input  logic                   alu_ready,
    input  logic                   lsu_ready,
    input  logic [NW-1:0]          mem_done,
    input  logic [NW*2-1:0]        inst_op,
    input  logic [NW*WS_LANES-1:0] inst_taken,
    input  logic [NW*PCW-1:0]      inst_tgt,
    input  logic [NW*PCW-1:0]      inst_rcv,
    output logic [NW*PCW-1:0]      fetch_pc,
    output logic                   issue_valid,
    output logic [((NW > 1) ? $clog2(NW) : 1)-1:0] issue_warp,
    output logic [1:0]             issue_op,
    output logic [WS_LANES-1:0]    issue_mask,
    output logic [PCW-1:0]         issue_pc
);
    localparam int WIW   = (NW > 1) ? $clog2(NW) : 1;
    localparam int TURNS = WS_LANES / LSU_LANES;
    localparam int TW    = (TURNS > 1) ? $clog2(TURNS) : 1;

    logic [PCW-1:0] pc_arr   [NW];
    lane_mask_t     mask_arr [NW];
    op_e            op_arr   [NW];
    logic [NW-1:0]  pend_vec, done_vec, resident, elig;

    logic [WIW-1:0] last_q, lock_w, gnt;
    logic           lock_q, any_req, final_turn;
    logic [TW-1:0]  turn_q;

    ws_occupancy #(.NW(NW), .RF_REGS(RF_REGS), .RPT_W(RPT_W)) occ_i (
        .regs_per_thread(regs_per_thread),
        .resident       (resident)
    );

    ws_rr_arb #(.N(NW), .IW(WIW)) arb_i (
        .req (elig),
        .last(last_q),
        .gnt (gnt),
        .any (any_req)
    );

    for (genvar w = 0; w < NW; w++) begin : g_warp
        always_comb begin
            op_arr[w] = op_e'(inst_op[w*2 +: 2]);
            elig[w]   = resident[w] && !done_vec[w] && !pend_vec[w] &&
                        ((op_arr[w] == OP_LDST) ? lsu_ready : alu_ready);
            fetch_pc[w*PCW +: PCW] = pc_arr[w];
        end

        ws_warp_ctx #(.PCW(PCW), .DEPTH(STK_DEPTH)) ctx_i (
            .clk       (clk),
            .rst       (rst),
            .issue     (issue_valid && (issue_warp == WIW'(w))),
            .final_turn(final_turn),
            .op        (op_e'(issue_op)),
            .taken     (inst_taken[w*WS_LANES +: WS_LANES]),
            .tgt       (inst_tgt[w*PCW +: PCW]),
            .rcv       (inst_rcv[w*PCW +: PCW]),
            .mem_done  (mem_done[w]),
            .pc        (pc_arr[w]),
            .mask      (mask_arr[w]),
            .pend      (pend_vec[w]),
            .done      (done_vec[w])
        );
    end

    always_comb begin
        if (lock_q) begin
            issue_valid = lsu_ready;
            issue_warp  = lock_w;
            issue_op    = OP_LDST;
            issue_mask  = mask_arr[lock_w] & lane_slice(int'(turn_q), LSU_LANES);
            final_turn  = (turn_q == TW'(TURNS - 1));
        end else begin
            issue_valid = any_req;
            issue_warp  = gnt;
            issue_op    = op_arr[gnt];
            issue_mask  = (op_arr[gnt] == OP_LDST) ?
                          (mask_arr[gnt] & lane_slice(0, LSU_LANES)) : mask_arr[gnt];
            final_turn  = (TURNS == 1);
        end
        issue_pc = pc_arr[issue_warp];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            lock_w <= '0;
            turn_q <= '0;
            last_q <= WIW'(NW - 1);
        end else if (issue_valid) begin
            if (lock_q) begin
                if (final_turn) begin
                    lock_q <= 1'b0;
                    turn_q <= '0;
                end else begin
                    turn_q <= turn_q + 1'b1;
                end
            end else begin
                last_q <= gnt;
                if ((issue_op == OP_LDST) && (TURNS > 1)) begin
                    lock_q <= 1'b1;
                    lock_w <= gnt;
                    turn_q <= TW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ws_sched_chk.sv
module ws_sched_chk #(
    parameter int NW        = 4,
    parameter int WIW       = 2,
    parameter int LSU_LANES = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           issue_valid,
    input logic [WIW-1:0] issue_warp,
    input logic [1:0]     issue_op,
    input logic [31:0]    issue_mask,
    input logic           alu_ready,
    input logic           final_turn,
    input logic [NW-1:0]  pend_vec,
    input logic [NW-1:0]  done_vec,
    input logic [NW-1:0]  resident
);
    // R5
    no_pend_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op == 2'd1 && $countones(issue_mask) >= 0 && !final_turn && !$past(issue_valid))
        |-> !pend_vec[issue_warp]);

    // R6
    turn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op == 2'd1 && !final_turn)
        |=> (!issue_valid || (issue_op == 2'd1 && issue_warp == $past(issue_warp))));

    // R6
    turn_width_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op == 2'd1) |-> ($countones(issue_mask) <= LSU_LANES));

    // R7
    resident_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> resident[issue_warp]);

    // R9
    exit_once_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> !done_vec[issue_warp]);

    // R3
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op != 2'd1) |-> (issue_mask != '0));

    // R8
    unit_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op != 2'd1) |-> alu_ready);
endmodule

bind ws_sched ws_sched_chk #(.NW(NW), .WIW(WIW), .LSU_LANES(LSU_LANES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .issue_valid(issue_valid),
    .issue_warp (issue_warp),
    .issue_op   (issue_op),
    .issue_mask (issue_mask),
    .alu_ready  (alu_ready),
    .final_turn (final_turn),
    .pend_vec   (pend_vec),
    .done_vec   (done_vec),
    .resident   (resident)
);

// File: tb/ws_sched_test.sv
`timescale 1ns/1ps
module ws_sched_test;
    localparam int NW = 4;
    localparam int PCW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] regs_per_thread = 8'd32;
    logic alu_ready = 1'b0, lsu_ready = 1'b0;
    logic [NW-1:0] mem_done = '0;
    logic [NW*2-1:0] inst_op;
    logic [NW*32-1:0] inst_taken;
    logic [NW*PCW-1:0] inst_tgt, inst_rcv, fetch_pc;
    logic issue_valid;
    logic [1:0] issue_warp, issue_op;
    logic [31:0] issue_mask;
    logic [PCW-1:0] issue_pc;

    always #2 clk = ~clk;

    ws_sched uut (
        .clk(clk), .rst(rst), .regs_per_thread(regs_per_thread),
        .alu_ready(alu_ready), .lsu_ready(lsu_ready), .mem_done(mem_done),
        .inst_op(inst_op), .inst_taken(inst_taken), .inst_tgt(inst_tgt),
        .inst_rcv(inst_rcv), .fetch_pc(fetch_pc), .issue_valid(issue_valid),
        .issue_warp(issue_warp), .issue_op(issue_op), .issue_mask(issue_mask),
        .issue_pc(issue_pc)
    );

    // per-warp program memories
    int          p_op [NW][64];
    logic [31:0] p_tk [NW][64];
    int          p_tg [NW][64];
    int          p_rc [NW][64];

    always_comb begin
        for (int w = 0; w < NW; w++) begin
            inst_op[w*2 +: 2]      = 2'(p_op[w][fetch_pc[w*PCW +: PCW]]);
            inst_taken[w*32 +: 32] = p_tk[w][fetch_pc[w*PCW +: PCW]];
            inst_tgt[w*PCW +: PCW] = PCW'(p_tg[w][fetch_pc[w*PCW +: PCW]]);
            inst_rcv[w*PCW +: PCW] = PCW'(p_rc[w][fetch_pc[w*PCW +: PCW]]);
        end
    end

    // bench model state
    int          m_pc [NW];
    logic [31:0] m_mask [NW];
    int          s_rpc [NW][4];
    int          s_npc [NW][4];
    logic [31:0] s_msk [NW][4];
    int          m_sp [NW];
    bit          m_pend [NW];
    bit          m_done [NW];
    int          cnt [NW];
    int          m_last, m_lw, m_turn, m_res;
    bit          m_lock;

    int n_chk = 0, n_bad = 0;
    int cyc_total = 0;

    function automatic logic [31:0] slice8(input int t);
        return 32'hFF << (8 * t);
    endfunction

    function automatic int resident_count(input int rpt);
        if (rpt == 0) return NW;
        if (4096 / (rpt * 32) >= NW) return NW;
        return 4096 / (rpt * 32);
    endfunction

    task automatic put(input int w, input int pc, input int op, input logic [31:0] tk, input int tg, input int rc);
        p_op[w][pc] = op; p_tk[w][pc] = tk; p_tg[w][pc] = tg; p_rc[w][pc] = rc;
    endtask

    task automatic load_programs();
        for (int w = 0; w < NW; w++)
            for (int a = 0; a < 64; a++) put(w, a, 3, '0, 0, 0);
        // warp 0: nested divergence with loads inside the paths
        put(0, 0, 0, '0, 0, 0);
        put(0, 1, 2, $urandom, 8, 10);
        put(0, 2, 0, '0, 0, 0);
        put(0, 3, 2, $urandom, 5, 6);
        put(0, 4, 1, '0, 0, 0);
        put(0, 5, 0, '0, 0, 0);
        put(0, 6, 0, '0, 0, 0);
        put(0, 7, 1, '0, 0, 0);
        put(0, 8, 0, '0, 0, 0);
        put(0, 9, 1, '0, 0, 0);
        put(0, 10, 0, '0, 0, 0);
        // warp 1: uniform taken branch skips the else path
        put(1, 0, 1, '0, 0, 0);
        put(1, 1, 0, '0, 0, 0);
        put(1, 2, 2, 32'hFFFF_FFFF, 4, 6);
        put(1, 3, 0, '0, 0, 0);
        put(1, 4, 0, '0, 0, 0);
        put(1, 5, 0, '0, 0, 0);
        // warp 2: uniform not-taken branch jumps
        put(2, 0, 2, 32'h0, 2, 4);
        put(2, 1, 0, '0, 0, 0);
        put(2, 2, 0, '0, 0, 0);
        put(2, 3, 1, '0, 0, 0);
        // warp 3: random mix then one branch
        for (int a = 0; a < 10; a++) put(3, a, int'($urandom % 2), '0, 0, 0);
        put(3, 10, 2, $urandom, 13, 16);
        for (int a = 11; a < 16; a++) put(3, a, int'($urandom % 2), '0, 0, 0);
        put(3, 16, 0, '0, 0, 0);
    endtask

    task automatic check(input bit ok, input string req, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic adv(input int w);
        int n;
        n = (m_pc[w] + 1) % 64;
        if (m_sp[w] > 0 && n == s_rpc[w][m_sp[w]-1]) begin
            m_pc[w]   = s_npc[w][m_sp[w]-1];
            m_mask[w] = s_msk[w][m_sp[w]-1];
            m_sp[w]--;
        end else begin
            m_pc[w] = n;
        end
    endtask

    task automatic push(input int w, input int r, input logic [31:0] mk, input int n);
        s_rpc[w][m_sp[w]] = r; s_msk[w][m_sp[w]] = mk; s_npc[w][m_sp[w]] = n;
        m_sp[w]++;
    endtask

    task automatic model_step(input bit ev, input int ew, input logic [NW-1:0] md);
        int op; bit fin; logic [31:0] tk, el;
        for (int w = 0; w < NW; w++) if (md[w]) m_pend[w] = 0;
        if (!ev) return;
        cnt[ew]++;
        op  = m_lock ? 1 : p_op[ew][m_pc[ew]];
        fin = m_lock && (m_turn == 3);
        if (m_lock) begin
            if (fin) begin m_lock = 0; m_turn = 0; end
            else m_turn++;
        end else begin
            m_last = ew;
            if (op == 1) begin m_lock = 1; m_lw = ew; m_turn = 1; end
        end
        case (op)
            0: adv(ew);
            1: if (fin) begin adv(ew); m_pend[ew] = 1; end
            2: begin
                tk = m_mask[ew] & p_tk[ew][m_pc[ew]];
                el = m_mask[ew] & ~p_tk[ew][m_pc[ew]];
                if (tk == 0) m_pc[ew] = p_tg[ew][m_pc[ew]];
                else if (el == 0) begin
                    push(ew, p_tg[ew][m_pc[ew]], m_mask[ew], p_rc[ew][m_pc[ew]]);
                    m_pc[ew]++;
                end else begin
                    push(ew, p_rc[ew][m_pc[ew]], m_mask[ew], p_rc[ew][m_pc[ew]]);
                    push(ew, p_tg[ew][m_pc[ew]], el, p_tg[ew][m_pc[ew]]);
                    m_mask[ew] = tk;
                    m_pc[ew]++;
                end
            end
            default: m_done[ew] = 1;
        endcase
    endtask

    task automatic run_phase(input int rpt);
        int cyc; bit ev, all_done, elig; int ew, eop, c; logic [31:0] emask; string tag;
        load_programs();
        regs_per_thread = 8'(rpt);
        m_res = resident_count(rpt);
        for (int w = 0; w < NW; w++) begin
            m_pc[w] = 0; m_mask[w] = '1; m_sp[w] = 0; m_pend[w] = 0; m_done[w] = 0; cnt[w] = 0;
        end
        m_last = NW - 1; m_lock = 0; m_turn = 0; m_lw = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cyc = 0;
        all_done = 0;
        while (!all_done && cyc < 4000) begin
            if (cyc == 0) begin
                alu_ready = 1; lsu_ready = 1; mem_done = '0;
            end else begin
                alu_ready = ($urandom % 8) != 0;
                lsu_ready = ($urandom % 8) != 0;
                for (int w = 0; w < NW; w++) mem_done[w] = m_pend[w] && (($urandom % 4) == 0);
            end
            #1;
            if (cyc == 0) begin
                // R1: reset state seen at the ports
                check(fetch_pc == '0, "R1", $sformatf("fetch_pc act=%h exp=0", fetch_pc));
                check(issue_valid && issue_warp == 0 && issue_mask == 32'hFFFF_FFFF, "R1",
                      $sformatf("first issue act v=%0d w=%0d m=%h exp v=1 w=0 m=ffffffff",
                                issue_valid, issue_warp, issue_mask));
            end
            ev = 0; ew = 0; eop = 0; emask = '0;
            if (m_lock) begin
                ev = lsu_ready; ew = m_lw; eop = 1; emask = m_mask[m_lw] & slice8(m_turn);
            end else begin
                for (int o = 1; o <= NW; o++) begin
                    c = (m_last + o) % NW;
                    elig = (c < m_res) && !m_done[c] && !m_pend[c] &&
                           ((p_op[c][m_pc[c]] == 1) ? lsu_ready : alu_ready);
                    if (!ev && elig) begin ev = 1; ew = c; end
                end
                if (ev) begin
                    eop = p_op[ew][m_pc[ew]];
                    emask = (eop == 1) ? (m_mask[ew] & slice8(0)) : m_mask[ew];
                end
            end
            if (m_lock || eop == 1) tag = "R6";
            else if (issue_valid != ev) tag = "R5";
            else if (ev && issue_warp != 2'(ew)) tag = "R2";
            else if (ev && issue_pc != PCW'(m_pc[ew])) tag = "R10";
            else if (eop == 2 || m_sp[ew] > 0) tag = "R4";
            else tag = "R3";
            check((issue_valid == ev) && (!ev || (issue_warp == 2'(ew) && issue_op == 2'(eop) &&
                   issue_mask == emask && issue_pc == PCW'(m_pc[ew]))), tag,
                  $sformatf("act v=%0d w=%0d op=%0d m=%h pc=%0d exp v=%0d w=%0d op=%0d m=%h pc=%0d",
                            issue_valid, issue_warp, issue_op, issue_mask, issue_pc,
                            ev, ew, eop, emask, m_pc[ew]));
            model_step(ev, ew, mem_done);
            all_done = !m_lock;
            for (int w = 0; w < m_res; w++) if (!m_done[w]) all_done = 0;
            @(negedge clk);
            cyc++;
            cyc_total++;
        end
        // watchdog per phase
        check(all_done, "R9", $sformatf("phase rpt=%0d stalled act done=0 exp done=1", rpt));
        for (int w = 0; w < NW; w++) begin
            if (w >= m_res)
                // R7
                check(cnt[w] == 0, "R7", $sformatf("warp %0d issues act=%0d exp=0", w, cnt[w]));
        end
        mem_done = '0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        run_phase(32);
        run_phase(48);
        run_phase(0);
        run_phase(128);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule